// File: doc/BRIEF.md
# UART Interrupt Status and Masking

This block gathers the seven interrupt causes of a serial port into one status word, gates that word with a per-cause enable mask, and drives a single interrupt request line. The request line is the OR of all enabled causes. The five error and timeout causes arrive as one-cycle pulses. The two FIFO-threshold causes arrive as levels. Each cause latches into its own raw status bit, and the bit stays set until software clears it.

Software reaches the block through a plain register port. It can load the enable mask, read the raw causes whatever the mask holds, and read the masked causes so that one handler can serve several causes at once. It clears causes by writing ones to a clear address.

Writes take effect at the clock edge where `wr_en` is high. The read port is combinational: `rd_data` follows `rd_addr` in the same cycle. The port has no handshake and no back-pressure. Every access completes in one cycle.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset, the mask, every raw status bit and `irq_o` are all zero.
- R2: The cause-to-bit mapping is fixed for `evt_i`, the mask and both status words: bit 0 receive threshold, bit 1 transmit threshold, bit 2 receive timeout, bit 3 framing error, bit 4 parity error, bit 5 break, bit 6 overrun. A high value on any of bits 2 to 6 at a clock edge sets that raw bit, and the bit stays set after the input falls.
- R3: Bits 0 and 1 set their raw bit only on a low-to-high transition of the input. A level that stays high after its bit has been cleared does not set the bit again.
- R4: Writing address 0 loads the mask from `wr_data`, and reading address 0 returns the mask.
- R5: Reading address 1 returns the raw status whatever the mask holds.
- R6: Reading address 2 returns the raw status ANDed with the mask.
- R7: `irq_o` is high exactly when at least one bit is set in both the raw status and the mask.
- R8: Writing address 3 clears every raw bit whose `wr_data` bit is 1. Bits written with 0 are unchanged. Reading address 3 returns zero.
- R9: If a cause sets a bit in the same cycle that a clear write targets it, the bit ends up set.
- R10: Writes to addresses 1 and 2 change neither the mask nor the raw status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 7 | Cause inputs, in the bit order given in R2 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 mask, 1 raw, 2 masked, 3 clear |
| wr_data | input | 7 | Write data |
| rd_addr | input | 2 | Read address, same map as the write address |
| rd_data | output | 7 | Combinational read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions take two things for granted. First, the causes on bits 2 to 6 are meaningful one cycle at a time. Second, a threshold input held high is a single event, not a stream of events. The stimulus therefore drives each pulse cause for exactly one cycle, and returns every cause to low between trials, so that each threshold bit sees a fresh rising edge. The sweep covers every combination of mask value and cause pattern. Directed cases then cover a held threshold level, a clear that coincides with a set, a clear written with zeros, and writes to the read-only addresses.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int unsigned NUM_EVT = 7;
  localparam int unsigned ADDR_W  = 2;

  // cause positions inside every status word
  localparam int unsigned EV_RX_LVL   = 0;
  localparam int unsigned EV_TX_LVL   = 1;
  localparam int unsigned EV_RX_TMO   = 2;
  localparam int unsigned EV_FRAME    = 3;
  localparam int unsigned EV_PARITY   = 4;
  localparam int unsigned EV_BREAK    = 5;
  localparam int unsigned EV_OVERRUN  = 6;

  // causes that arrive as levels and are edge-detected
  localparam logic [NUM_EVT-1:0] EDGE_SRC_DEFAULT =
    (NUM_EVT'(1) << EV_RX_LVL) | (NUM_EVT'(1) << EV_TX_LVL);

  typedef enum logic [ADDR_W-1:0] {
    A_MASK   = 2'd0,
    A_RAW    = 2'd1,
    A_MASKED = 2'd2,
    A_CLEAR  = 2'd3
  } irq_addr_e;

endpackage

// File: rtl/uart_irq_cell.sv
module uart_irq_cell #(
  parameter bit EDGE_MODE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic clr_i,
  output logic stat_o
);

  logic set_w;
  logic stat_q;

  generate
    if (EDGE_MODE) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= src_i;
      end
      assign set_w = src_i & ~prev_q;

      // R3: a fresh rising level always lands in status
      a_r3_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_i) |=> stat_o);
    end else begin : g_pulse
      assign set_w = src_i;

      // R2: a pulse cause is captured at its edge
      a_r2_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
        src_i |=> stat_o);
    end
  endgenerate

  // set has priority over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     stat_q <= 1'b0;
    else if (set_w) stat_q <= 1'b1;
    else if (clr_i) stat_q <= 1'b0;
  end

  assign stat_o = stat_q;

  // R8: clear without a set empties the bit
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_w) |=> !stat_o);

  // R9: a set and a clear together leave the bit set
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && set_w) |=> stat_o);

  // R2: without set or clear the bit holds
  a_r2_bit_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_w && !clr_i) |=> $stable(stat_o));

endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
  import uart_irq_pkg::*;
#(
  parameter int unsigned N = NUM_EVT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [N-1:0]      wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [N-1:0]      raw_i,
  output logic [N-1:0]      mask_o,
  output logic [N-1:0]      clr_o,
  output logic [N-1:0]      rd_data
);

  irq_addr_e wsel, rsel;
  logic [N-1:0] mask_q;

  assign wsel = irq_addr_e'(wr_addr);
  assign rsel = irq_addr_e'(rd_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       mask_q <= '0;
    else if (wr_en && wsel == A_MASK) mask_q <= wr_data;
  end

  assign mask_o = mask_q;
  assign clr_o  = (wr_en && wsel == A_CLEAR) ? wr_data : '0;

  always_comb begin
    unique case (rsel)
      A_MASK:   rd_data = mask_q;
      A_RAW:    rd_data = raw_i;
      A_MASKED: rd_data = raw_i & mask_q;
      default:  rd_data = '0;
    endcase
  end

  // R4: a mask write lands on the next cycle
  a_r4_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_MASK) |=> (mask_o == $past(wr_data)));

  // R10: writes to the status addresses leave the mask alone
  a_r10_ro_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == A_RAW || wr_addr == A_MASKED)) |=> $stable(mask_o));

  // R8: only the clear address produces clear strobes
  a_r8_clear_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_o != '0) |-> (wr_en && wr_addr == A_CLEAR));

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int unsigned       N        = NUM_EVT,
  parameter logic [N-1:0]      EDGE_SRC = EDGE_SRC_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      evt_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [N-1:0]      wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [N-1:0]      rd_data,
  output logic              irq_o
);

  logic [N-1:0] raw_w;
  logic [N-1:0] mask_w;
  logic [N-1:0] clr_w;

  uart_irq_regs #(.N(N)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .raw_i   (raw_w),
    .mask_o  (mask_w),
    .clr_o   (clr_w),
    .rd_data (rd_data)
  );

  generate
    for (genvar i = 0; i < N; i++) begin : g_cell
      uart_irq_cell #(.EDGE_MODE(EDGE_SRC[i])) u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (evt_i[i]),
        .clr_i  (clr_w[i]),
        .stat_o (raw_w[i])
      );
    end
  endgenerate

  assign irq_o = |(raw_w & mask_w);

  // R7: no request while every cause is disabled
  a_r7_mask_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_w == '0) |-> !irq_o);

  // R7: a request always has a pending cause behind it
  a_r7_needs_raw: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (raw_w != '0));

  // R10: a write to a status address cannot clear anything
  a_r10_ro_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == A_RAW || wr_addr == A_MASKED)) |=> ((raw_w & $past(raw_w)) == $past(raw_w)));

endmodule

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] evt_i = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [6:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [6:0] rd_data;
  logic       irq_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  uart_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_o(irq_o)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [6:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [6:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [6:0] v;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    rd(2'd0, v); chk("R1 mask", v, 7'h00);
    rd(2'd1, v); chk("R1 raw", v, 7'h00);
    chk("R1 irq", {6'd0, irq_o}, 7'h00);
    rst_n = 1'b1;
    tick();
    rd(2'd1, v); chk("R1 raw after release", v, 7'h00);

    // R2 R4 R5 R6 R7: every mask against every cause pattern
    for (int m = 0; m < 128; m++) begin
      wr(2'd0, 7'(m));
      rd(2'd0, v); chk("R4 mask readback", v, 7'(m));
      for (int e = 0; e < 128; e++) begin
        wr(2'd3, 7'h7f);
        evt_i = 7'(e);
        tick();
        evt_i = '0;
        tick();
        rd(2'd1, v); chk("R5 raw", v, 7'(e));
        rd(2'd2, v); chk("R6 masked", v, 7'(e & m));
        chk("R7 irq", {6'd0, irq_o}, {6'd0, |(7'(e & m))});
      end
    end

    // R8 partial clear and zero write
    wr(2'd0, 7'h7f);
    wr(2'd3, 7'h7f);
    evt_i = 7'h7f; tick(); evt_i = '0; tick();
    wr(2'd3, 7'h00);
    rd(2'd1, v); chk("R8 zero clear", v, 7'h7f);
    wr(2'd3, 7'h55);
    rd(2'd1, v); chk("R8 partial clear", v, 7'h2a);
    rd(2'd3, v); chk("R8 clear reads zero", v, 7'h00);

    // R10 writes to status addresses
    wr(2'd1, 7'h00);
    wr(2'd2, 7'h00);
    rd(2'd1, v); chk("R10 raw kept", v, 7'h2a);
    rd(2'd0, v); chk("R10 mask kept", v, 7'h7f);

    // R9 set beats clear in the same cycle (parity, bit 4)
    wr(2'd3, 7'h7f);
    evt_i = 7'h10;
    wr(2'd3, 7'h10);
    evt_i = '0;
    rd(2'd1, v); chk("R9 set wins", v, 7'h10);
    chk("R9 irq", {6'd0, irq_o}, 7'h01);

    // R3 held threshold level does not re-set after clear
    wr(2'd3, 7'h7f);
    evt_i = 7'h01; tick();
    rd(2'd1, v); chk("R3 rise sets", v, 7'h01);
    wr(2'd3, 7'h01);
    tick(); tick();
    rd(2'd1, v); chk("R3 held level ignored", v, 7'h00);
    evt_i = 7'h00; tick();
    evt_i = 7'h01; tick();
    rd(2'd1, v); chk("R3 new rise sets", v, 7'h01);
    evt_i = '0;

    // R2 pulse cause held high keeps setting despite clear (overrun, bit 6)
    wr(2'd3, 7'h7f);
    evt_i = 7'h40;
    wr(2'd3, 7'h40);
    rd(2'd1, v); chk("R2 held pulse source", v, 7'h40);
    evt_i = '0;
    wr(2'd0, 7'h00);
    chk("R7 masked off", {6'd0, irq_o}, 7'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule